// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives a low-speed USB bus pair from a small byte buffer. A single start strobe launches a packet of 2 to 12 bytes, where the count includes a sync byte that the block produces itself. The remaining bytes are fetched from the caller's buffer through a combinational read port, indexed from zero. The caller must hold the buffer contents stable while the block reports busy. Each bit lasts a fixed number of clocks. The output line pair is placed in the idle J state one clock before the drivers are switched on. Bits are sent least significant first, NRZI coded and bit-stuffed. The packet ends with the end-of-packet pattern, after which the bus is released.

A handshake select input replaces the buffer with a one-byte reply, either ACK or NAK, sent after the sync byte. An active device address register takes the caller's pending address at the end of every data packet. Handshake replies never update it, so an address assignment only takes effect once its status-stage data packet has gone out.

FSM states: IDLE (bus released, waiting for start), PRESET (lines at J, drivers off, one clock), SEND (serialising bits), SE0 (both lines low, two bit times), EOPJ (J for one bit time), RELEASE (drivers off, lines low, done pulse, address commit). Transitions: IDLE to PRESET on start. PRESET to SEND after one clock. SEND to SE0 at the bit boundary once the last byte and any pending stuff bit have gone out. SE0 to EOPJ after its second bit period. EOPJ to RELEASE at the bit boundary. RELEASE to IDLE after one clock.

Top module: `usbtx_top`

## Requirements
- R1: A start accepted in IDLE gives exactly one clock with dm=1, dp=0 and oe=0. On the next clock, oe rises and the lines carry the first coded bit.
- R2: The sync byte 0x80 goes out first. It is followed by len-1 bytes read at rd_addr 0, 1, … in order. Every byte is sent least significant bit first.
- R3: len counts the sync byte and must lie between 2 and 12 when a data packet is started.
- R4: NRZI coding is used, where J is dp=0/dm=1 and K is dp=1/dm=0. A 0 bit toggles the line state and a 1 bit holds it. Each bit, stuffed or not, lasts BIT_CLKS clocks, and the lines change only at bit boundaries.
- R5: After six consecutive 1 bits, an extra toggle is inserted. The run count carries across byte boundaries, and a stuff bit that falls due after the last bit is still sent before the end of packet.
- R6: The end of packet is dp=dm=0 with oe=1 for two bit times, then J for one bit time. This is followed by one clock with oe=0, dp=dm=0 and done=1, and then IDLE.
- R7: With hs_sel=1, the packet is sync plus one PID byte: 0xD2 (ACK) if hs_nak=0, or 0x5A (NAK) if hs_nak=1. In this mode len and rd_data have no effect.
- R8: dev_addr takes new_addr on the clock that ends the done cycle, but only for data packets. It is unchanged after a handshake.
- R9: A start pulse while busy is ignored. No second packet follows the current one.
- R10: After reset, oe=0, dp=dm=0, busy=0, done=0 and dev_addr=0.
- R11: oe is high only from the first coded bit to the end of the trailing J. While oe is high, dp and dm are never both high, and while idle, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a packet (one clock, accepted only when idle) |
| len | input | BYTE_W | Byte count including sync (2..MAX_BYTES) |
| hs_sel | input | 1 | Send a handshake reply instead of the buffer |
| hs_nak | input | 1 | Handshake kind: 0 = ACK, 1 = NAK |
| rd_addr | output | BYTE_W | Buffer index of the byte being sent |
| rd_data | input | 8 | Buffer byte at rd_addr |
| new_addr | input | ADDR_W | Pending device address |
| dev_addr | output | ADDR_W | Active device address |
| dp | output | 1 | D+ line value |
| dm | output | 1 | D- line value |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-clock pulse as the bus is released |

## Verification
The checker watches, on every cycle, several properties. It checks that the drivers come on only after a clock of preset J. It checks that the lines never show both high and stay put between bit boundaries. It also checks that the release cycle and the idle state keep all lines low, that the address register moves only in the done cycle, and that start lengths are legal. Three things only the bench's packets can show: whether the emitted symbol stream is the correct NRZI and stuffed image of the sync, buffer or PID bytes, whether stuffing carries over byte edges and past the last byte, and whether handshakes leave the address alone while data packets commit it.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESET,
        ST_SEND,
        ST_SE0,
        ST_EOPJ,
        ST_RELEASE
    } tx_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;
endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
    parameter int BIT_CLKS = 8,
    localparam int CW = $clog2(BIT_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(BIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/usbtx_nrzi_stuff.sv
module usbtx_nrzi_stuff #(
    parameter int RUN_MAX = 6,
    localparam int OW = $clog2(RUN_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic emit,
    input  logic data_bit,
    output logic lvl,
    output logic stuff_due,
    output logic take
);
    logic [OW-1:0] ones;

    assign stuff_due = (ones == OW'(RUN_MAX));
    assign take      = emit && !stuff_due;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl  <= 1'b1;
            ones <= '0;
        end else if (init) begin
            lvl  <= 1'b1;
            ones <= '0;
        end else if (emit) begin
            if (stuff_due || !data_bit) begin
                lvl  <= ~lvl;
                ones <= '0;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usbtx_top.sv
module usbtx_top
    import usbtx_pkg::*;
#(
    parameter int BIT_CLKS  = 8,
    parameter int MAX_BYTES = 12,
    parameter int ADDR_W    = 7,
    parameter int RUN_MAX   = 6,
    localparam int BYTE_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] len,
    input  logic              hs_sel,
    input  logic              hs_nak,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dp,
    output logic              dm,
    output logic              oe,
    output logic              busy,
    output logic              done
);
    tx_state_e         state, state_nx;
    logic [BYTE_W-1:0] len_r, byte_no;
    logic [2:0]        bidx;
    logic              hs_r, nak_r, half;
    logic              bit_tick, lvl, stuff_due, take, emit, finished;
    logic [7:0]        cur_byte;

    usbtx_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE || state == ST_PRESET),
        .tick  (bit_tick)
    );

    always_comb begin
        if (byte_no == '0) cur_byte = SYNC_BYTE;
        else if (hs_r)     cur_byte = nak_r ? PID_NAK : PID_ACK;
        else               cur_byte = rd_data;
    end

    assign rd_addr  = byte_no - 1'b1;
    assign finished = (byte_no == len_r) && !stuff_due;
    assign emit     = (state == ST_PRESET) ||
                      (state == ST_SEND && bit_tick && !finished);

    usbtx_nrzi_stuff #(.RUN_MAX(RUN_MAX)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (state == ST_IDLE),
        .emit      (emit),
        .data_bit  (cur_byte[bidx]),
        .lvl       (lvl),
        .stuff_due (stuff_due),
        .take      (take)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_PRESET;
            ST_PRESET:  state_nx = ST_SEND;
            ST_SEND:    if (bit_tick && finished) state_nx = ST_SE0;
            ST_SE0:     if (bit_tick && half) state_nx = ST_EOPJ;
            ST_EOPJ:    if (bit_tick) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            len_r    <= '0;
            hs_r     <= 1'b0;
            nak_r    <= 1'b0;
            byte_no  <= '0;
            bidx     <= '0;
            half     <= 1'b0;
            dev_addr <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                len_r   <= hs_sel ? BYTE_W'(2) : len;
                hs_r    <= hs_sel;
                nak_r   <= hs_nak;
                byte_no <= '0;
                bidx    <= '0;
            end
            if (take) begin
                bidx <= bidx + 1'b1;
                if (bidx == 3'd7) byte_no <= byte_no + 1'b1;
            end
            if (state == ST_SEND)                half <= 1'b0;
            else if (state == ST_SE0 && bit_tick) half <= 1'b1;
            if (state == ST_RELEASE && !hs_r) dev_addr <= new_addr;
        end
    end

    always_comb begin
        oe   = 1'b0;
        dp   = 1'b0;
        dm   = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_PRESET:  dm = 1'b1;
            ST_SEND: begin
                oe = 1'b1;
                dm = lvl;
                dp = ~lvl;
            end
            ST_SE0:     oe = 1'b1;
            ST_EOPJ: begin
                oe = 1'b1;
                dm = 1'b1;
            end
            ST_RELEASE: done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/usbtx_checker.sv
module usbtx_checker #(
    parameter int BYTE_W    = 4,
    parameter int ADDR_W    = 7,
    parameter int MAX_BYTES = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [BYTE_W-1:0] len,
    input logic              hs_sel,
    input logic              busy,
    input logic              done,
    input logic              oe,
    input logic              dp,
    input logic              dm,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              bit_tick
);
    // R1: drivers come on only after a clock of J with drivers off
    p_preset_j_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(dm && !dp && !oe && busy));

    // R3: legal data packet length at start
    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !hs_sel) |-> (len >= 2 && len <= BYTE_W'(MAX_BYTES)));

    // R4: lines change only at bit boundaries while driven
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !bit_tick) |=> $stable({dp, dm}));

    // R6: release cycle has lines low, drivers off, then idle
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!oe && !dp && !dm));
    p_release_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: address register moves only at the done cycle
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(dev_addr));

    // R9: a running packet is not cut short
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11: no both-high while driven, quiet when idle
    p_no_se1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !(dp && dm));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!oe && !dp && !dm));
endmodule

bind usbtx_top usbtx_checker #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .hs_sel(hs_sel),
    .busy(busy), .done(done), .oe(oe), .dp(dp), .dm(dm),
    .dev_addr(dev_addr), .bit_tick(bit_tick)
);

// File: tb/sim_usbtx_top.sv
module sim_usbtx_top;
    localparam int CPB = 8;
    localparam int NV  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] len = 4'd0;
    logic       hs_sel = 1'b0, hs_nak = 1'b0;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic [6:0] new_addr = 7'd0;
    logic [6:0] dev_addr;
    logic       dp, dm, oe, busy, done;

    logic [7:0] bufm [0:15];
    logic [7:0] exp_bytes [0:15];
    logic [1:0] exp_sym [0:199];
    int         n_sym;
    logic [6:0] exp_addr;
    int         checks = 0, failures = 0;

    always #5 clk = ~clk;
    assign rd_data = bufm[rd_addr];

    usbtx_top #(.BIT_CLKS(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .hs_sel(hs_sel),
        .hs_nak(hs_nak), .rd_addr(rd_addr), .rd_data(rd_data),
        .new_addr(new_addr), .dev_addr(dev_addr), .dp(dp), .dm(dm),
        .oe(oe), .busy(busy), .done(done)
    );

    // {new_addr, len, hs_sel, hs_nak, seed, step}
    localparam logic [28:0] VEC [NV] = '{
        {7'h05, 4'd2,  1'b0, 1'b0, 8'hFF, 8'h00},
        {7'h11, 4'd4,  1'b0, 1'b0, 8'hFF, 8'h00},
        {7'h22, 4'd12, 1'b0, 1'b0, 8'h3C, 8'h11},
        {7'h33, 4'd5,  1'b0, 1'b0, 8'h00, 8'h00},
        {7'h44, 4'd9,  1'b1, 1'b0, 8'hFF, 8'h01},
        {7'h55, 4'd3,  1'b1, 1'b1, 8'hFF, 8'h00},
        {7'h66, 4'd3,  1'b0, 1'b0, 8'h7E, 8'h81}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // expected symbols as {dp,dm}: J=01, K=10, SE0=00
    task automatic build_expected(input int nbytes);
        logic lv = 1'b1;
        int   ones = 0;
        n_sym = 0;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (!exp_bytes[b][i]) begin lv = ~lv; ones = 0; end
                else ones++;
                exp_sym[n_sym] = {~lv, lv}; n_sym++;
                if (ones == 6) begin
                    lv = ~lv; ones = 0;
                    exp_sym[n_sym] = {~lv, lv}; n_sym++;
                end
            end
        end
        exp_sym[n_sym] = 2'b00; n_sym++;
        exp_sym[n_sym] = 2'b00; n_sym++;
        exp_sym[n_sym] = 2'b01; n_sym++;
    endtask

    task automatic run_packet(input logic [6:0] na, input logic [3:0] ln,
                              input logic hs, input logic nk,
                              input logic [7:0] seed, input logic [7:0] step,
                              input bit poke);
        int  nbytes, bad, first_bad, first_act;
        bit  oe_ok;
        for (int i = 0; i < 16; i++) bufm[i] = seed + 8'(i) * step;
        exp_bytes[0] = 8'h80;
        if (hs) begin
            nbytes = 2;
            exp_bytes[1] = nk ? 8'h5A : 8'hD2;
        end else begin
            nbytes = int'(ln);
            for (int i = 1; i < nbytes; i++) exp_bytes[i] = bufm[i-1];
        end
        build_expected(nbytes);

        @(negedge clk);
        new_addr = na; len = ln; hs_sel = hs; hs_nak = nk; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!oe && dm && !dp && busy, "R1", "preset J with oe low",
            {oe, dp, dm, busy}, 4'b0011);
        @(posedge clk);
        bad = 0; first_bad = -1; first_act = 0; oe_ok = 1'b1;
        for (int s = 0; s < n_sym; s++) begin
            @(negedge clk);
            if ({dp, dm} !== exp_sym[s]) begin
                if (first_bad < 0) begin first_bad = s; first_act = {dp, dm}; end
                bad++;
            end
            if (!oe) oe_ok = 1'b0;
            if (poke && s == 5) start = 1'b1;
            if (poke && s == 6) start = 1'b0;
            repeat (CPB) @(posedge clk);
        end
        if (first_bad < 0) first_bad = 0;
        chk(bad == 0, hs ? "R7" : "R2 R4 R5", "symbol stream",
            first_act, exp_sym[first_bad]);
        chk(oe_ok, "R11", "oe high during packet", 0, 1);
        @(negedge clk);
        chk(done && !oe && !dp && !dm, "R6", "release cycle",
            {done, oe, dp, dm}, 4'b1000);
        if (!hs) exp_addr = na;
        @(posedge clk);
        @(negedge clk);
        chk(!busy, "R6", "idle after release", busy, 0);
        chk(dev_addr == exp_addr, "R8", "device address", dev_addr, exp_addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_addr = 7'd0;
        for (int i = 0; i < 16; i++) bufm[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!oe && !dp && !dm && !busy && !done && dev_addr == 0, "R10",
            "reset state", {oe, dp, dm, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!oe && !busy, "R11", "quiet idle", {oe, busy}, 0);

        for (int v = 0; v < NV; v++) begin
            run_packet(VEC[v][28:22], VEC[v][21:18], VEC[v][17], VEC[v][16],
                       VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R9: start pulse mid-packet must not launch another packet
        run_packet(7'h7F, 4'd2, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b1);
        begin
            bit stayed = 1'b1;
            for (int c = 0; c < 3 * CPB; c++) begin
                @(negedge clk);
                if (busy || oe) stayed = 1'b0;
            end
            chk(stayed, "R9", "no packet after ignored start", !stayed, 0);
        end

        // R3 boundary: maximum-length packet of alternating ones runs
        run_packet(7'h01, 4'd12, 1'b0, 1'b0, 8'hFE, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule